// File: doc/BRIEF.md
# Synchronous Serial Shift Data Path

This block moves data in and out over a clocked serial link. It holds two byte-wide data registers, a low byte and a high byte. In byte mode only the low byte is used. In word mode the two bytes are chained into one 16-bit shift path. Each shift clock period sends the least significant bit of the low byte on the serial output and takes one bit in from the serial input. In byte mode the incoming bit enters the top of the low byte. In word mode it enters the top of the high byte, and the bottom bit of the high byte moves down into the top of the low byte.

A host reaches four byte-wide locations through a simple write strobe, a read strobe and a two-bit address. A write to the control location with the start bit set begins a transfer. `busy` stays high until the last bit has been shifted in, and `done` then pulses for one cycle. A clock-stop register resets to all ones. Clearing its gate bit puts the block in standby. In standby, shift clock edges and start requests are ignored and the transfer state holds.

The shift clock is sampled by the system clock `clk`. A falling shift clock edge updates the output bit. A rising edge samples the input bit and shifts the registers. The shift clock idles high.

Top module: `sync_shift_path`

## Requirements
- R1: In byte mode (control bit 0 = 0), a transfer of 8 shift clock periods sends the low byte (address 0) LSB first. Afterwards the low byte holds the 8 received bits, with the first received bit in bit 0.
- R2: In word mode (control bit 0 = 1), a transfer of 16 periods sends the low byte and then the high byte (address 1), LSB first. Afterwards the first received bit is in low bit 0 and the last received bit is in high bit 7.
- R3: `so` resets to 1. It changes only in the clock cycle after a sampled falling `sclk` edge during a busy, non-standby transfer, and it takes the low byte's current bit 0.
- R4: `si` is sampled at the rising `sclk` edge. Each such edge during a transfer shifts the path by one place toward bit 0.
- R5: A byte-mode transfer leaves the high byte unchanged.
- R6: The clock-stop register at address 3 resets to 8'hFF and reads back any value written to it. Bit STOP_BIT (default 7) is the gate bit for this block.
- R7: While the gate bit is 0, `sclk` edges and start requests have no effect and the transfer state holds. Setting the bit to 1 again resumes the transfer where it stopped.
- R8: A control write (address 2) with bit 1 = 1, made while idle and not in standby, sets `busy` from the next cycle. The bit count is 8 or 16, taken from bit 0 of the same write. `busy` falls after the last rising edge, and `done` is high for exactly that one cycle.
- R9: A control write while `busy` is high is ignored. It neither restarts the transfer nor changes the mode.
- R10: Any host read or write of address 0 or 1 while `busy` is high raises `acc_err` for one cycle in the following cycle. Such writes are dropped.
- R11: A read of address 2 returns `busy` in bit 7 and the mode in bit 0, with zeros in the other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Shift clock, idles high, sampled by clk |
| si | input | 1 | Serial data input |
| so | output | 1 | Serial data output |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (used for access flagging) |
| host_addr | input | 2 | 0 low byte, 1 high byte, 2 control, 3 clock stop |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| acc_err | output | 1 | Data register accessed during a transfer |

## Verification
The assertions take `sclk` to be slow against `clk` and to idle high when a transfer starts, so that each period produces exactly one sampled fall followed by one sampled rise. The bench holds each shift clock phase for three system clocks, always starts with a falling edge and sets `si` at that fall. The assertions also take the shift clock not to change at the same time as the gate bit. The bench writes the clock-stop register only while `sclk` rests high between periods. Data register contents are checked only when idle, after values have been written or shifted in.

// File: rtl/sync_shift_path.sv
module sync_shift_path #(
  parameter int STOP_BIT = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       si,
  output logic       so,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [1:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       busy,
  output logic       done,
  output logic       acc_err
);
  localparam int BYTE_BITS = 8;
  localparam int WORD_BITS = 2 * BYTE_BITS;
  localparam int CW = $clog2(WORD_BITS + 1);

  logic [BYTE_BITS-1:0] lo_q, up_q, ckstp_q;
  logic [CW-1:0]        cnt_q;
  logic mode_q, busy_q, done_q, err_q, so_q, sclk_q;

  wire run      = ckstp_q[STOP_BIT];
  wire sc_rise  = sclk & ~sclk_q;
  wire sc_fall  = ~sclk & sclk_q;
  wire wr_lo    = host_wr && host_addr == 2'd0;
  wire wr_up    = host_wr && host_addr == 2'd1;
  wire wr_ctl   = host_wr && host_addr == 2'd2;
  wire wr_ck    = host_wr && host_addr == 2'd3;
  wire start    = wr_ctl && host_wdata[1] && !busy_q && run;
  wire shift    = busy_q && run && sc_rise;
  wire lo_top   = mode_q ? up_q[0] : si;

  always_ff @(posedge clk) begin
    if (shift) begin
      lo_q <= {lo_top, lo_q[BYTE_BITS-1:1]};
      if (mode_q) up_q <= {si, up_q[BYTE_BITS-1:1]};
    end else if (!busy_q) begin
      if (wr_lo) lo_q <= host_wdata;
      if (wr_up) up_q <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ckstp_q <= '1;
      mode_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      so_q    <= 1'b1;
      sclk_q  <= 1'b1;
      cnt_q   <= '0;
    end else begin
      sclk_q <= sclk;
      done_q <= 1'b0;
      err_q  <= busy_q && (host_wr || host_rd) && !host_addr[1];
      if (wr_ck) ckstp_q <= host_wdata;
      if (wr_ctl && !busy_q) mode_q <= host_wdata[0];
      if (busy_q && run && sc_fall) so_q <= lo_q[0];
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= host_wdata[0] ? CW'(WORD_BITS) : CW'(BYTE_BITS);
      end else if (shift) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (host_addr)
      2'd0:    host_rdata = lo_q;
      2'd1:    host_rdata = up_q;
      2'd2:    host_rdata = {busy_q, 6'b0, mode_q};
      default: host_rdata = ckstp_q;
    endcase
  end

  assign so      = so_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign acc_err = err_q;
endmodule

// File: rtl/sync_shift_path_chk.sv
module sync_shift_path_chk #(
  parameter int STOP_BIT = 7
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic       so,
  input logic       busy,
  input logic       done,
  input logic       acc_err,
  input logic [7:0] ckstp,
  input logic [4:0] cnt,
  input logic       mode
);
  AST_SO_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && ckstp[STOP_BIT] && $fell(sclk)) |=> $stable(so)); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_AT_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R8
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt != 5'd0 && cnt <= 5'd16)); // R8
  AST_STANDBY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ckstp[STOP_BIT]) |=> (busy && $stable(cnt))); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !($rose(sclk) && ckstp[STOP_BIT])) |=> ($stable(cnt) && $stable(mode))); // R9
  AST_ERR_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(busy)); // R10
endmodule

bind sync_shift_path sync_shift_path_chk #(.STOP_BIT(STOP_BIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .so(so), .busy(busy), .done(done),
  .acc_err(acc_err), .ckstp(ckstp_q), .cnt(cnt_q), .mode(mode_q)
);

// File: tb/sync_shift_path_tb_top.sv
module sync_shift_path_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, si = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic so, busy, done, acc_err;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sync_shift_path dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .si(si), .so(so),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .done(done), .acc_err(acc_err)
  );

  // behavioural reference
  logic [7:0] m_lo, m_up, m_ck;
  bit m_mode, m_busy, m_done, m_err, m_so, m_prev;
  int m_cnt;
  bit q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ck = 8'hFF; m_mode = 0; m_busy = 0; m_done = 0; m_err = 0;
      m_so = 1; m_prev = 1; m_cnt = 0; q.delete();
    end else begin
      bit b0, run, rise, fall;
      b0 = m_busy; run = m_ck[7];
      rise = sclk && !m_prev; fall = !sclk && m_prev; m_prev = sclk;
      m_done = 0;
      m_err = b0 && (host_wr || host_rd) && host_addr < 2;
      if (b0 && run && fall) m_so = q[0];
      if (b0 && run && rise) begin
        void'(q.pop_front()); q.push_back(si); m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1;
          for (int i = 0; i < 8; i++) m_lo[i] = q[i];
          if (q.size() == 16) for (int i = 0; i < 8; i++) m_up[i] = q[i+8];
        end
      end
      if (host_wr) begin
        if (!b0 && host_addr == 0) m_lo = host_wdata;
        if (!b0 && host_addr == 1) m_up = host_wdata;
        if (!b0 && host_addr == 2) begin
          m_mode = host_wdata[0];
          if (host_wdata[1] && run) begin
            q.delete();
            for (int i = 0; i < 8; i++) q.push_back(m_lo[i]);
            if (m_mode) for (int i = 0; i < 8; i++) q.push_back(m_up[i]);
            m_cnt = m_mode ? 16 : 8; m_busy = 1;
          end
        end
        if (host_addr == 3) m_ck = host_wdata;
      end
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    tests++;
    if (so !== m_so || busy !== m_busy || done !== m_done || acc_err !== m_err) begin
      fails++;
      $display("FAIL R3/R8/R10 outputs so=%b busy=%b done=%b err=%b exp so=%b busy=%b done=%b err=%b",
               so, busy, done, acc_err, m_so, m_busy, m_done, m_err);
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; #1 d = host_rdata;
  endtask

  task automatic pulse(input bit b);
    @(negedge clk); sclk = 0; si = b;
    repeat (3) @(negedge clk);
    sclk = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic shift_n(input int n, input logic [15:0] pat);
    for (int i = 0; i < n; i++) pulse(pat[i]);
  endtask

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // reset state
    rd(2'd3, d); chk("R6 ckstp reset", d, 8'hFF);
    rd(2'd2, d); chk("R11 ctl reset", d, 8'h00);
    chk("R3 so reset", {7'b0, so}, 8'h01);
    // clock-stop register read/write
    wr(2'd3, 8'h5A); rd(2'd3, d); chk("R6 ckstp rw", d, 8'h5A);
    wr(2'd3, 8'hFF); rd(2'd3, d); chk("R6 ckstp rw2", d, 8'hFF);
    // byte mode
    wr(2'd0, 8'hA5); wr(2'd1, 8'h3C);
    wr(2'd2, 8'h02);
    rd(2'd2, d); chk("R11 ctl busy byte", d, 8'h80);
    shift_n(8, 16'h0096);
    rd(2'd0, d); chk("R1 R4 low after byte", d, m_lo);
    chk("R1 low value", d, 8'h96);
    rd(2'd1, d); chk("R5 high untouched", d, 8'h3C);
    rd(2'd2, d); chk("R8 idle after byte", d, 8'h00);
    // word mode with ignored control write and flagged access
    wr(2'd0, 8'h12); wr(2'd1, 8'hC7);
    wr(2'd2, 8'h03);
    shift_n(3, 16'h0001);
    wr(2'd2, 8'h02);
    rd(2'd2, d); chk("R9 mode kept", d, 8'h81);
    @(negedge clk); host_rd = 1; host_addr = 2'd0;
    @(negedge clk); host_rd = 0;
    shift_n(13, 16'hB4E1 >> 3);
    rd(2'd0, d); chk("R2 low after word", d, m_lo);
    chk("R2 low value", d, 8'hE1 & 8'hF8 | 8'h01);
    rd(2'd1, d); chk("R2 high after word", d, m_up);
    rd(2'd2, d); chk("R8 idle after word", d, 8'h01);
    // standby
    wr(2'd3, 8'h7F); wr(2'd2, 8'h02);
    rd(2'd2, d); chk("R7 no start in standby", d, 8'h00);
    wr(2'd3, 8'hFF); wr(2'd0, 8'h5C); wr(2'd2, 8'h02);
    shift_n(2, 16'h0003);
    wr(2'd3, 8'h7F);
    shift_n(3, 16'h0007);
    rd(2'd2, d); chk("R7 held busy", d, 8'h80);
    wr(2'd3, 8'hFF);
    shift_n(6, 16'h002D);
    rd(2'd0, d); chk("R7 resumed result", d, m_lo);
    chk("R7 resumed value", d, 8'hB7);
    rd(2'd2, d); chk("R8 idle after resume", d, 8'h00);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule